// File: doc/BRIEF.md
# Range Maintenance Request Sequencer

This block is a small bus master that carries out one cache maintenance request at a time against a memory-mapped operation queue. A request names a start address, an end address, a way mask, an operation code, a scope (address range, whole cache, or selected ways) and a target. For range requests the sequencer snaps the range to 128-byte lines and cuts it into commands no longer than the queue accepts in one go. It then walks each command through the queue's protocol: clear the completion flag, post the command with its side registers, re-post while the queue rejects it, and poll until the command has finished.

Invalidate requests get special care at the edges. A line that the range covers only in part is flushed instead of invalidated, so data that shares the line but lies outside the range is kept. Every request, even one that issues no commands, ends with a sync: the sequencer writes the drain code to the primitive register and reads that register back. The request side is a valid/ready handshake, and a one-cycle done pulse marks the end. The queue sits outside this block.

Top module: `rms_seq`

## Requirements
- R1: `req_ready` is high after reset and whenever the block is idle. It goes low the cycle after a request is accepted and stays low until `done` has pulsed high for exactly one cycle.
- R2: For range scope, the first command's address is the start address rounded down to a 128-byte boundary. Every write to the address register (selector 2) is line-aligned.
- R3: For range scope, the total length covered runs from the rounded-down start to the end address, rounded up to a multiple of 128 bytes, so partial first and last lines are included.
- R4: A range is split into commands of min(remaining, 4 MiB − 128 bytes) bytes. After each command the address advances and the remaining length shrinks by that amount. Every size write (selector 3) is nonzero, line-aligned and no larger than the limit.
- R5: Per command the order is fixed. First write 0x4 to the status register (selector 0). Then write the command word (selector 1). For range scope only, write the address (selector 2) and then the size (selector 3). Write the way mask (selector 4) only when the scope is ways or the target is ways. Then read the set-result register (selector 5).
- R6: If the set-result read returns a nonzero value in bits 1:0, the command word and its side registers are written again, followed by another set-result read.
- R7: After an accepted command the status register (selector 0) is read repeatedly until it returns exactly 0x4. Only then does the next command or the sync start.
- R8: After the last command (or at once when there is none), 0x8 is written to the primitive register (selector 6), that register is read once, and `done` follows.
- R9: For an invalidate (op 0) range request, an unaligned start line and an unaligned end line are each flushed (op 2) as a single 128-byte command. These run head first and tail last, and the aligned interior between them is invalidated.
- R10: For an invalidate request whose range leaves no aligned interior after the edge lines are removed, only the edge flushes and the sync are issued.
- R11: Whole-cache (scope 1) and way (scope 2) requests issue exactly one command with no address or size writes, then the sync.
- R12: A range request whose end address is at or below its start address issues no command, only the sync.
- R13: A bus transaction completes on a cycle where `m_valid` and `m_ready` are both high, and read data is taken on that cycle. While `m_ready` is low, `m_valid`, `m_write`, `m_sel` and `m_wdata` hold.
- R14: The command word has the operation in bits 2:0, the notify bit at bit 15, the scope in bits 18:17 (0 range, 1 whole cache, 2 ways) and the target in bits 22:21 (0 data, 1 instruction, 2 ways). A request scope of 3 is treated as range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_start | input | AW | First byte address of the range |
| req_end | input | AW | Address one past the last byte |
| req_ways | input | WAYW | Way mask for way scope or way target |
| req_op | input | 3 | Operation code |
| req_scope | input | 2 | 0 range, 1 whole cache, 2 ways |
| req_target | input | 2 | 0 data, 1 instruction, 2 explicit ways |
| done | output | 1 | One-cycle pulse when the request is finished |
| m_valid | output | 1 | Bus transaction requested |
| m_write | output | 1 | 1 write, 0 read |
| m_sel | output | 3 | Queue register selector |
| m_wdata | output | DW | Write data |
| m_ready | input | 1 | Transaction completes this cycle |
| m_rdata | input | DW | Read data, valid with m_ready |

## Verification
The bench aims at the places where the line arithmetic is easy to get wrong. These include a range that starts and ends mid-line, an invalidate that fits inside one line, a range that ends exactly on a line boundary, and a nine-megabyte range that needs three commands with a short last one. A design that rounded the wrong way would post a shorter size or a shifted address. One that invalidated edge lines, or dropped the second edge of a single-line range, would show the wrong operation code or one command too few.

The queue model rejects commands and stays busy for several polls, and it stretches handshakes. A sequencer that skipped the retry, polled for the wrong value or advanced without `m_ready` would fall out of step with the expected transaction stream. Empty ranges and whole-cache or way-scope requests catch address and size writes that should not appear.

// File: rtl/rms_pkg.sv
package rms_pkg;

   typedef enum logic [2:0] {
      SEL_STAT = 3'd0,
      SEL_CMD  = 3'd1,
      SEL_ADDR = 3'd2,
      SEL_SIZE = 3'd3,
      SEL_WAYS = 3'd4,
      SEL_SETR = 3'd5,
      SEL_PRIM = 3'd6
   } rms_sel_e;

   localparam logic [1:0] SCP_RANGE = 2'd0;
   localparam logic [1:0] SCP_ALL   = 2'd1;
   localparam logic [1:0] SCP_WAY   = 2'd2;
   localparam logic [1:0] TGT_WAYS  = 2'd2;

   localparam logic [2:0] OP_INV   = 3'd0;
   localparam logic [2:0] OP_FLUSH = 3'd2;

   localparam int NOTIFY_BIT = 15;
   localparam int SCOPE_LSB  = 17;
   localparam int TGT_LSB    = 21;
   localparam int DONE_BIT   = 2;
   localparam int SYNC_CODE  = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PLAN,
      ST_CLR,
      ST_CMD,
      ST_ADR,
      ST_SIZ,
      ST_WAY,
      ST_CHK,
      ST_POLL,
      ST_SYW,
      ST_SYR,
      ST_FIN
   } rms_state_e;

endpackage

// File: rtl/rms_range_plan.sv
// Splits a captured request range into up to three segments:
// index 0 head edge line, 1 body, 2 tail edge line.
module rms_range_plan #(
   parameter int AW         = 32,
   parameter int LINE_BYTES = 128
) (
   input  logic [AW-1:0]       start_addr,
   input  logic [AW-1:0]       end_addr,
   input  logic                is_inv,
   output logic [2:0]          need,
   output logic [2:0][AW:0]    base,
   output logic [2:0][AW:0]    size
);
   localparam int W  = AW + 1;
   localparam int LB = $clog2(LINE_BYTES);
   localparam logic [W-1:0] LINE = W'(LINE_BYTES);
   localparam logic [W-1:0] MASK = ~(LINE - 1'b1);

   logic          s_un, e_un;
   logic [W-1:0]  s, e, s_dn, e_dn, s_up;

   generate
      if (LB == 0) begin : g_byte_lines
         assign s_un = 1'b0;
         assign e_un = 1'b0;
      end else begin : g_wide_lines
         assign s_un = |start_addr[LB-1:0];
         assign e_un = |end_addr[LB-1:0];
      end
   endgenerate

   assign s    = {1'b0, start_addr};
   assign e    = {1'b0, end_addr};
   assign s_dn = s & MASK;
   assign e_dn = e & MASK;
   assign s_up = s_un ? (s_dn + LINE) : s;

   always_comb begin
      need = 3'b000;
      base = '0;
      size = '0;
      if (is_inv) begin
         need[0] = s_un;
         base[0] = s_dn;
         size[0] = LINE;
         need[1] = (s_up < e_dn);
         base[1] = s_up;
         size[1] = e_dn - s_up;
         need[2] = e_un;
         base[2] = e_dn;
         size[2] = LINE;
      end else begin
         need[1] = 1'b1;
         base[1] = s_dn;
         size[1] = (e - s_dn + (LINE - 1'b1)) & MASK;
      end
   end

   // R3: a non-invalidate body covers the whole requested range
   always_comb begin
      if (!is_inv && (e > s)) begin
         a_r3_body_covers_end: assert ((base[1] + size[1]) >= e);
      end
   end

   // R2: body base is always line aligned
   always_comb begin
      a_r2_body_aligned: assert ((base[1] & (LINE - 1'b1)) == '0);
   end

endmodule

// File: rtl/rms_chunk_step.sv
// Picks the next command length and the state after it.
module rms_chunk_step #(
   parameter int AW        = 32,
   parameter int CHUNK_MAX = 4194304 - 128
) (
   input  logic [AW:0] addr,
   input  logic [AW:0] rem,
   output logic [AW:0] chunk,
   output logic [AW:0] nxt_addr,
   output logic [AW:0] nxt_rem,
   output logic        last
);
   localparam logic [AW:0] LIM = (AW+1)'(CHUNK_MAX);

   generate
      if (longint'(CHUNK_MAX) >= (longint'(1) << AW)) begin : g_no_split
         assign chunk = rem;
      end else begin : g_split
         assign chunk = (rem > LIM) ? LIM : rem;
      end
   endgenerate

   assign nxt_addr = addr + chunk;
   assign nxt_rem  = rem - chunk;
   assign last     = (nxt_rem == '0);

endmodule

// File: rtl/rms_cmd_fmt.sv
// Builds the command word and decides which side registers follow it.
module rms_cmd_fmt #(
   parameter int DW = 32
) (
   input  logic [1:0]    scope,
   input  logic [1:0]    target,
   input  logic [2:0]    op,
   output logic [DW-1:0] word,
   output logic          use_range,
   output logic          use_ways
);
   import rms_pkg::*;

   always_comb begin
      word = '0;
      word[NOTIFY_BIT]       = 1'b1;
      word[SCOPE_LSB +: 2]   = scope;
      word[TGT_LSB +: 2]     = target;
      word[2:0]              = op;
   end

   assign use_range = (scope == SCP_RANGE);
   assign use_ways  = (scope == SCP_WAY) || (target == TGT_WAYS);

endmodule

// File: rtl/rms_seq.sv
module rms_seq #(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int WAYW       = 32,
   parameter int LINE_BYTES = 128,
   parameter int CHUNK_MAX  = 4194304 - 128
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [AW-1:0]   req_start,
   input  logic [AW-1:0]   req_end,
   input  logic [WAYW-1:0] req_ways,
   input  logic [2:0]      req_op,
   input  logic [1:0]      req_scope,
   input  logic [1:0]      req_target,
   output logic            done,
   output logic            m_valid,
   output logic            m_write,
   output logic [2:0]      m_sel,
   output logic [DW-1:0]   m_wdata,
   input  logic            m_ready,
   input  logic [DW-1:0]   m_rdata
);
   import rms_pkg::*;

   localparam logic [DW-1:0] DONE_VAL = DW'(1 << DONE_BIT);
   localparam logic [DW-1:0] SYNC_VAL = DW'(SYNC_CODE);

   generate
      if ((LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("LINE_BYTES must be a power of two");
      end
      if ((CHUNK_MAX % LINE_BYTES) != 0 || CHUNK_MAX < LINE_BYTES) begin : g_bad_chunk
         $error("CHUNK_MAX must be a nonzero multiple of LINE_BYTES");
      end
      if (DW < AW || DW < TGT_LSB + 2) begin : g_bad_dw
         $error("DW too narrow for addresses or command word");
      end
      if (WAYW > DW) begin : g_bad_ways
         $error("WAYW must not exceed DW");
      end
   endgenerate

   rms_state_e      st;
   logic [AW-1:0]   r_start, r_end;
   logic [WAYW-1:0] r_ways;
   logic [2:0]      r_op;
   logic [1:0]      r_scope, r_tgt;
   logic [1:0]      cur_seg;
   logic [AW:0]     cur_addr, rem;

   logic            r_range, r_is_inv;
   logic [2:0]      cur_op;
   logic [2:0]      plan_need;
   logic [2:0][AW:0] plan_base, plan_size;
   logic [AW:0]     chunk, nxt_addr, nxt_rem;
   logic            last;
   logic [DW-1:0]   cmd_word;
   logic            use_range, use_ways;
   logic            first_hit, after_hit;
   logic [1:0]      first_idx, after_idx;
   logic            xfer, poll_ok, rejected;

   assign r_range  = (r_scope == SCP_RANGE);
   assign r_is_inv = r_range && (r_op == OP_INV);
   assign cur_op   = (r_is_inv && cur_seg != 2'd1) ? OP_FLUSH : r_op;

   rms_range_plan #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_plan (
      .start_addr (r_start),
      .end_addr   (r_end),
      .is_inv     (r_is_inv),
      .need       (plan_need),
      .base       (plan_base),
      .size       (plan_size)
   );

   rms_chunk_step #(.AW(AW), .CHUNK_MAX(CHUNK_MAX)) u_chunk (
      .addr     (cur_addr),
      .rem      (rem),
      .chunk    (chunk),
      .nxt_addr (nxt_addr),
      .nxt_rem  (nxt_rem),
      .last     (last)
   );

   rms_cmd_fmt #(.DW(DW)) u_cmd (
      .scope     (r_scope),
      .target    (r_tgt),
      .op        (cur_op),
      .word      (cmd_word),
      .use_range (use_range),
      .use_ways  (use_ways)
   );

   // lowest needed segment, and lowest needed segment after the current one
   always_comb begin
      first_hit = 1'b0;
      first_idx = 2'd0;
      after_hit = 1'b0;
      after_idx = 2'd0;
      for (int j = 2; j >= 0; j--) begin
         if (plan_need[j]) begin
            first_hit = 1'b1;
            first_idx = 2'(j);
         end
         if (plan_need[j] && (2'(j) > cur_seg)) begin
            after_hit = 1'b1;
            after_idx = 2'(j);
         end
      end
   end

   assign xfer     = m_valid && m_ready;
   assign poll_ok  = (m_rdata == DONE_VAL);
   assign rejected = |m_rdata[1:0];

   // bus outputs decoded from state
   always_comb begin
      m_valid = 1'b1;
      m_write = 1'b1;
      m_sel   = 3'(SEL_STAT);
      m_wdata = '0;
      unique case (st)
         ST_CLR:  begin m_sel = 3'(SEL_STAT); m_wdata = DONE_VAL; end
         ST_CMD:  begin m_sel = 3'(SEL_CMD);  m_wdata = cmd_word; end
         ST_ADR:  begin m_sel = 3'(SEL_ADDR); m_wdata = DW'(cur_addr); end
         ST_SIZ:  begin m_sel = 3'(SEL_SIZE); m_wdata = DW'(chunk); end
         ST_WAY:  begin m_sel = 3'(SEL_WAYS); m_wdata = DW'(r_ways); end
         ST_CHK:  begin m_sel = 3'(SEL_SETR); m_write = 1'b0; end
         ST_POLL: begin m_sel = 3'(SEL_STAT); m_write = 1'b0; end
         ST_SYW:  begin m_sel = 3'(SEL_PRIM); m_wdata = SYNC_VAL; end
         ST_SYR:  begin m_sel = 3'(SEL_PRIM); m_write = 1'b0; end
         default: begin m_valid = 1'b0; m_write = 1'b0; end
      endcase
   end

   assign req_ready = (st == ST_IDLE);
   assign done      = (st == ST_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         r_start  <= '0;
         r_end    <= '0;
         r_ways   <= '0;
         r_op     <= '0;
         r_scope  <= SCP_RANGE;
         r_tgt    <= '0;
         cur_seg  <= 2'd1;
         cur_addr <= '0;
         rem      <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (req_valid) begin
               r_start <= req_start;
               r_end   <= req_end;
               r_ways  <= req_ways;
               r_op    <= req_op;
               r_tgt   <= req_target;
               r_scope <= (req_scope == SCP_ALL || req_scope == SCP_WAY) ?
                          req_scope : SCP_RANGE;
               st      <= ST_PLAN;
            end
            ST_PLAN: begin
               if (!r_range) begin
                  st <= ST_CLR;
               end else if (r_end <= r_start || !first_hit) begin
                  st <= ST_SYW;
               end else begin
                  cur_seg  <= first_idx;
                  cur_addr <= plan_base[first_idx];
                  rem      <= plan_size[first_idx];
                  st       <= ST_CLR;
               end
            end
            ST_CLR: if (xfer) st <= ST_CMD;
            ST_CMD: if (xfer) st <= use_range ? ST_ADR : (use_ways ? ST_WAY : ST_CHK);
            ST_ADR: if (xfer) st <= ST_SIZ;
            ST_SIZ: if (xfer) st <= use_ways ? ST_WAY : ST_CHK;
            ST_WAY: if (xfer) st <= ST_CHK;
            ST_CHK: if (xfer) st <= rejected ? ST_CMD : ST_POLL;
            ST_POLL: if (xfer && poll_ok) begin
               if (!r_range) begin
                  st <= ST_SYW;
               end else if (!last) begin
                  cur_addr <= nxt_addr;
                  rem      <= nxt_rem;
                  st       <= ST_CLR;
               end else if (after_hit) begin
                  cur_seg  <= after_idx;
                  cur_addr <= plan_base[after_idx];
                  rem      <= plan_size[after_idx];
                  st       <= ST_CLR;
               end else begin
                  st <= ST_SYW;
               end
            end
            ST_SYW: if (xfer) st <= ST_SYR;
            ST_SYR: if (xfer) st <= ST_FIN;
            ST_FIN: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r2_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_write && m_sel == 3'(SEL_ADDR)) |->
      ((m_wdata & DW'(LINE_BYTES - 1)) == '0));

   a_r4_size_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_write && m_sel == 3'(SEL_SIZE)) |->
      (m_wdata != '0 && (m_wdata & DW'(LINE_BYTES - 1)) == '0 &&
       m_wdata <= DW'(CHUNK_MAX)));

   a_r5_clear_value: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_write && m_sel == 3'(SEL_STAT)) |-> (m_wdata == DONE_VAL));

   a_r6_retry_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !m_write && m_sel == 3'(SEL_SETR) && m_rdata[1:0] != 2'b00) |=>
      (m_valid && m_write && m_sel == 3'(SEL_CMD)));

   a_r7_keep_polling: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !m_write && m_sel == 3'(SEL_STAT) && m_rdata != DONE_VAL) |=>
      (m_valid && !m_write && m_sel == 3'(SEL_STAT)));

   a_r8_sync_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && m_write && m_sel == 3'(SEL_PRIM)) |=>
      (m_valid && !m_write && m_sel == 3'(SEL_PRIM)));

   a_r8_done_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(xfer && !m_write && m_sel == 3'(SEL_PRIM)));

   a_r11_no_range_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && (m_sel == 3'(SEL_ADDR) || m_sel == 3'(SEL_SIZE))) |-> r_range);

   a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=>
      (m_valid && $stable(m_write) && $stable(m_sel) && $stable(m_wdata)));

endmodule

// File: tb/rms_seq_tb_top.sv
`timescale 1ns/1ps
module rms_seq_tb_top;

   localparam longint LINE = 128;
   localparam longint MAXC = 4194304 - 128;

   typedef struct {
      bit     w;
      int     sel;
      longint d;
   } xact_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_start = '0, req_end = '0, req_ways = '0;
   logic [2:0]  req_op = '0;
   logic [1:0]  req_scope = '0, req_target = '0;
   logic        done;
   logic        m_valid, m_write;
   logic [2:0]  m_sel;
   logic [31:0] m_wdata;
   logic        m_ready = 1'b0;
   logic [31:0] m_rdata = '0;

   xact_t  expq[$];
   int     n_chk = 0, n_fail = 0;
   int     rej_n = 0, busy_n = 0, stall_n = 0;
   int     rej_left = 0, busy_left = 0, wctr = 0;
   string  tag = "R1 reset";

   rms_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_start(req_start), .req_end(req_end), .req_ways(req_ways),
      .req_op(req_op), .req_scope(req_scope), .req_target(req_target),
      .done(done),
      .m_valid(m_valid), .m_write(m_write), .m_sel(m_sel), .m_wdata(m_wdata),
      .m_ready(m_ready), .m_rdata(m_rdata)
   );

   initial forever #10 clk = ~clk;

   task automatic chk(bit ok, string msg, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL [%s] %s: actual %0h expected %0h", tag, msg, act, exp);
      end
   endtask

   function automatic longint cmdw(int scope, int tgt, int op);
      return (longint'(1) << 15) | (longint'(scope) << 17) |
             (longint'(tgt) << 21) | longint'(op);
   endfunction

   task automatic push(bit w, int sel, longint d);
      xact_t x;
      x.w = w; x.sel = sel; x.d = d;
      expq.push_back(x);
   endtask

   // expected stream of one command (R5, R6, R7)
   task automatic exp_chunk(longint cmd, bit rng, longint a, longint s,
                            bit wf, longint wy);
      push(1, 0, 4);
      for (int r = 0; r <= rej_n; r++) begin
         push(1, 1, cmd);
         if (rng) begin
            push(1, 2, a);
            push(1, 3, s);
         end
         if (wf) push(1, 4, wy);
         push(0, 5, 0);
      end
      for (int b = 0; b <= busy_n; b++) push(0, 0, 0);
   endtask

   // range alignment and splitting (R2, R3, R4)
   task automatic exp_span(longint st, longint en, int op, int tgt, longint wy);
      longint base, sz, c;
      if (en <= st) return;
      base = st & ~(LINE - 1);
      sz   = ((en - base) + LINE - 1) & ~(LINE - 1);
      while (sz > 0) begin
         c = (sz > MAXC) ? MAXC : sz;
         exp_chunk(cmdw(0, tgt, op), 1, base, c, tgt == 2, wy);
         base += c;
         sz   -= c;
      end
   endtask

   // invalidate with edge flushes (R9, R10)
   task automatic exp_inv(longint st, longint en, int tgt, longint wy);
      longint lo, hi, s;
      if (en <= st) return;
      lo = st & ~(LINE - 1);
      hi = en & ~(LINE - 1);
      s  = st;
      if ((st % LINE) != 0) begin
         exp_span(lo, lo + LINE, 2, tgt, wy);
         s = lo + LINE;
      end
      if (s < hi) exp_span(s, hi, 0, tgt, wy);
      if ((en % LINE) != 0) exp_span(hi, hi + LINE, 2, tgt, wy);
   endtask

   // queue model and scoreboard monitor, one step per falling edge
   task automatic slave_step();
      xact_t  e;
      longint act, exp;
      if (!m_valid) begin
         m_ready = 1'b0;
         wctr = 0;
      end else if (wctr < stall_n) begin
         m_ready = 1'b0;
         wctr++;
      end else begin
         m_ready = 1'b1;
         wctr = 0;
         act = (longint'(m_write) << 40) | (longint'(m_sel) << 32) |
               (m_write ? longint'(m_wdata) : 0);
         if (expq.size() == 0) begin
            chk(0, "R5 unexpected bus transaction", act, -1);
         end else begin
            e = expq.pop_front();
            exp = (longint'(e.w) << 40) | (longint'(e.sel) << 32) | (e.w ? e.d : 0);
            chk(act == exp, "R5 R14 bus transaction write/sel/data", act, exp);
         end
         m_rdata = '0;
         if (m_write && m_sel == 3'd0) begin
            rej_left  = rej_n;
            busy_left = busy_n;
         end else if (!m_write && m_sel == 3'd5) begin
            if (rej_left > 0) begin
               m_rdata = (rej_left % 2 == 1) ? 32'h1 : 32'h2;
               rej_left--;
            end
         end else if (!m_write && m_sel == 3'd0) begin
            if (busy_left > 0) begin
               m_rdata = 32'h1;
               busy_left--;
            end else begin
               m_rdata = 32'h4;
            end
         end
      end
   endtask

   initial begin
      @(negedge clk);
      forever begin
         slave_step();
         @(negedge clk);
      end
   end

   task automatic run_req(longint st, longint en, longint wy, int op,
                          int scope, int tgt, string t);
      int cnt;
      tag = t;
      if (scope != 0)
         exp_chunk(cmdw(scope, tgt, op), 0, 0, 0, (scope == 2 || tgt == 2), wy);
      else if (op == 0)
         exp_inv(st, en, tgt, wy);
      else
         exp_span(st, en, op, tgt, wy);
      push(1, 6, 8);   // R8 sync write
      push(0, 6, 0);   // R8 sync readback
      req_valid  = 1'b1;
      req_start  = 32'(st);
      req_end    = 32'(en);
      req_ways   = 32'(wy);
      req_op     = 3'(op);
      req_scope  = 2'(scope);
      req_target = 2'(tgt);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R1 ready low after accept", req_ready, 0);
      cnt = 0;
      while (!done && cnt < 20000) begin
         @(negedge clk);
         cnt++;
      end
      chk(done == 1'b1, "R1 done pulse seen", done, 1);
      chk(expq.size() == 0, "R8 all expected transactions issued before done",
          expq.size(), 0);
      expq.delete();
      @(negedge clk);
      chk(done == 1'b0, "R1 done lasts one cycle", done, 0);
      chk(req_ready == 1'b1, "R1 ready back after done", req_ready, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL [watchdog] R1 run did not finish: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
      chk(m_valid == 1'b0, "R1 reset bus idle", m_valid, 0);
      chk(done == 1'b0, "R1 reset done low", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

      run_req(64'h1010, 64'h1220, 0, 2, 0, 0, "R2 R3 R14 flush unaligned range");
      rej_n = 2; busy_n = 3;
      run_req(64'h1010, 64'h1220, 0, 1, 0, 1, "R6 R7 retry and poll");
      rej_n = 1; busy_n = 1;
      run_req(64'h100000, 64'hA00000, 0, 1, 0, 0, "R4 three-chunk split");
      rej_n = 0; busy_n = 0;
      run_req(64'h2040, 64'h2390, 0, 0, 0, 0, "R9 invalidate with two edges");
      run_req(64'h3010, 64'h3020, 0, 0, 0, 0, "R10 invalidate inside one line");
      run_req(64'h4000, 64'h4100, 0, 0, 0, 0, "R9 invalidate aligned");
      run_req(64'h5000, 64'h5000, 0, 2, 0, 0, "R12 empty range");
      run_req(64'h5100, 64'h5000, 0, 2, 0, 0, "R12 reversed range");
      run_req(0, 0, 0, 2, 1, 0, "R11 whole cache flush");
      busy_n = 2;
      run_req(0, 0, 64'hF, 0, 2, 0, "R11 R5 way-scope invalidate");
      busy_n = 0;
      run_req(64'h6000, 64'h6081, 64'h3, 3, 0, 2, "R5 R14 prefetch to ways");
      stall_n = 2; rej_n = 1;
      run_req(64'h7000, 64'h7100, 0, 2, 0, 0, "R13 R8 stalled handshakes");
      stall_n = 0; rej_n = 0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule